// File: doc/BRIEF.md
# SAR Converter Serial Output Sequencer

This block is the digital half of a 12-bit successive-approximation converter that talks over a three-wire serial port. An external master pulls the active-low select line down and toggles a data clock. The sequencer then runs a short sampling window and resolves one result bit on each falling data-clock edge. It drives every bit onto the serial line in the same edge in which the bit is decided, so the bits on the line always belong to the conversion in progress. Once the least significant bit is out, further edges replay the word in the opposite order. After that the line goes quiet until the select line has been released and asserted again.

The block drives a trial word to the capacitor array and receives a single comparator decision back. The block samples the select line and the data clock with its own fast clock, and both are treated as synchronous to it. A fall of the data clock is detected as a one-to-zero change between two samples. Raising the select line at any moment aborts the conversion, so a master that needs only the top few bits can stop early.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset the output is disabled and the trial word is zero. If the select line is low when reset releases, no data-clock edge starts a conversion until the select line has been seen high.
- R2: After the select line falls, the first falling data-clock edge leaves the output disabled. The second falling edge enables the output and drives a 0 null bit.
- R3: The next 12 falling edges drive the result bits in order B11 down to B0, one new bit per falling edge.
- R4: Each bit is driven in the same falling edge in which it is decided, with no pipeline delay. The word on the line is the one being converted and not the previous one.
- R5: After B0, 11 further falling edges drive B1 up to B11.
- R6: The falling edge after the repeated B11 disables the output. It stays disabled for any number of further edges while the select line is held low.
- R7: A new conversion starts only when the select line goes high and then low again.
- R8: While the select line is high, from the next clock on, the output is disabled, the power-down flag is set and the trial word is zero, whatever phase was running.
- R9: The result is straight binary. An input code of 000h gives all-zero bits and FFFh gives all-one bits.
- R10: The comparator decision cmp_keep is 1 when the input is at or above the trial word, which keeps the bit under test. While bit n is under test, the trial word holds the decided bits above n, a 1 at n and zeros below. The decision for bit n is latched on the falling edge that outputs it, and the trial word then equals the result.
- R11: The analog-idle flag is low from the start of a conversion until B0 is decided, and high from then on. The power-down flag is low while the select line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and powers down |
| dclk | input | 1 | External data clock; falling edges step the sequence |
| cmp_keep | input | 1 | Comparator decision, 1 keeps the bit under test |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Serial data drive enable, 0 means high impedance |
| trial | output | 12 | Trial word for the capacitor array |
| analog_idle | output | 1 | No sampling or bit decision pending |
| full_pd | output | 1 | Full power-down while the select line is high |

## Verification
The bound checker watches four things on every cycle. A high select line forces the output off, the power-down flag on and the trial word to zero. The first driven bit after the output enables is always the low null bit. The output stays off once a frame is spent and the select line is still low. The trial word moves only after a sampled data-clock low or a select release. The ordering of the twelve decided bits, the mirrored replay, the comparator-driven values, the analog-idle timing and the reset lock-out depend on the whole stimulus history, so only the bench scenarios show them. The bench drives a frame per table entry, an aborted frame and a reset with the select line held low.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   // Sequencer phases; ST_LOCK waits for the select line to go high
   typedef enum logic [2:0] {
      ST_LOCK = 3'd0,
      ST_IDLE = 3'd1,
      ST_SAMP = 3'd2,
      ST_NULL = 3'd3,
      ST_CONV = 3'd4,
      ST_RPLY = 3'd5,
      ST_DONE = 3'd6
   } seq_st_e;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter  int RES_BITS     = 12,
   parameter  int SAMPLE_EDGES = 2,
   localparam int IW           = $clog2(RES_BITS + 1),
   localparam int CW           = $clog2(SAMPLE_EDGES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          dclk,
   output seq_st_e       state,
   output logic [IW-1:0] idx,
   output logic          ev_arm,
   output logic          ev_dec,
   output logic          ev_rep,
   output logic          ev_clr
);

   logic          dclk_q;
   logic          dfall;
   logic [CW-1:0] scnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dclk_q <= 1'b0;
      else        dclk_q <= dclk;
   end

   assign dfall  = dclk_q & ~dclk;

   assign ev_clr = cs_n;
   assign ev_arm = !cs_n && dfall && (state == ST_SAMP) &&
                   (scnt == CW'(SAMPLE_EDGES - 1));
   assign ev_dec = !cs_n && dfall &&
                   ((state == ST_NULL) || (state == ST_CONV));
   assign ev_rep = !cs_n && dfall && (state == ST_RPLY) &&
                   (idx != IW'(RES_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_LOCK;
         idx   <= '0;
         scnt  <= '0;
      end else if (cs_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         scnt  <= '0;
      end else begin
         case (state)
            ST_LOCK: state <= ST_LOCK;
            ST_IDLE: begin
               state <= ST_SAMP;
               scnt  <= '0;
            end
            ST_SAMP: begin
               if (ev_arm) begin
                  state <= ST_NULL;
                  idx   <= IW'(RES_BITS - 1);
               end else if (dfall) begin
                  scnt  <= scnt + 1'b1;
               end
            end
            ST_NULL, ST_CONV: begin
               if (ev_dec) begin
                  if (idx == '0) begin
                     state <= ST_RPLY;
                     idx   <= IW'(1);
                  end else begin
                     state <= ST_CONV;
                     idx   <= idx - 1'b1;
                  end
               end
            end
            ST_RPLY: begin
               if (ev_rep)     idx   <= idx + 1'b1;
               else if (dfall) state <= ST_DONE;
            end
            ST_DONE: state <= ST_DONE;
            default: state <= ST_LOCK;
         endcase
      end
   end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter  int RES_BITS = 12,
   localparam int IW       = $clog2(RES_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_arm,
   input  logic                ev_dec,
   input  logic                ev_rep,
   input  logic                ev_clr,
   input  logic [IW-1:0]       idx,
   input  logic                cmp_keep,
   output logic [RES_BITS-1:0] trial,
   output logic                bit_q
);

   logic rep_bit;

   // One approximation flop per result bit
   for (genvar b = 0; b < RES_BITS; b++) begin : g_bit
      logic t_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        t_q <= 1'b0;
         else if (ev_clr)                   t_q <= 1'b0;
         else if (ev_arm)                   t_q <= (b == RES_BITS - 1);
         else if (ev_dec && idx == IW'(b))  t_q <= cmp_keep;
         else if (ev_dec && idx == IW'(b + 1)) t_q <= 1'b1;
      end
      assign trial[b] = t_q;
   end

   // Replay selects a decided bit by index
   always_comb begin
      rep_bit = 1'b0;
      for (int i = 0; i < RES_BITS; i++) begin
         if (idx == IW'(i)) rep_bit = trial[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               bit_q <= 1'b0;
      else if (ev_clr || ev_arm) bit_q <= 1'b0;
      else if (ev_dec)          bit_q <= cmp_keep;
      else if (ev_rep)          bit_q <= rep_bit;
   end

endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage
   import sar_seq_pkg::*;
#(
   parameter bit PARK_LOW = 1'b1
) (
   input  seq_st_e state,
   input  logic    bit_q,
   output logic    sdo,
   output logic    sdo_en,
   output logic    analog_idle,
   output logic    full_pd
);

   assign sdo_en = (state == ST_NULL) || (state == ST_CONV) ||
                   (state == ST_RPLY);

   if (PARK_LOW) begin : g_park_low
      assign sdo = sdo_en & bit_q;
   end else begin : g_park_hold
      assign sdo = bit_q;
   end

   assign analog_idle = (state == ST_LOCK) || (state == ST_IDLE) ||
                        (state == ST_RPLY) || (state == ST_DONE);
   assign full_pd     = (state == ST_IDLE);

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
   import sar_seq_pkg::*;
#(
   parameter int RES_BITS     = 12,
   parameter int SAMPLE_EDGES = 2,
   parameter bit PARK_LOW     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                dclk,
   input  logic                cmp_keep,
   output logic                sdo,
   output logic                sdo_en,
   output logic [RES_BITS-1:0] trial,
   output logic                analog_idle,
   output logic                full_pd
);

   localparam int IW = $clog2(RES_BITS + 1);

   if (RES_BITS < 2) begin : g_bad_res
      $error("sar_serial_seq: RES_BITS must be at least 2");
   end
   if (SAMPLE_EDGES < 1) begin : g_bad_samp
      $error("sar_serial_seq: SAMPLE_EDGES must be at least 1");
   end

   seq_st_e       state;
   logic [IW-1:0] idx;
   logic          ev_arm, ev_dec, ev_rep, ev_clr;
   logic          bit_q;

   sar_seq_ctrl #(
      .RES_BITS     (RES_BITS),
      .SAMPLE_EDGES (SAMPLE_EDGES)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .dclk   (dclk),
      .state  (state),
      .idx    (idx),
      .ev_arm (ev_arm),
      .ev_dec (ev_dec),
      .ev_rep (ev_rep),
      .ev_clr (ev_clr)
   );

   sar_trial_reg #(
      .RES_BITS (RES_BITS)
   ) u_trial (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_arm   (ev_arm),
      .ev_dec   (ev_dec),
      .ev_rep   (ev_rep),
      .ev_clr   (ev_clr),
      .idx      (idx),
      .cmp_keep (cmp_keep),
      .trial    (trial),
      .bit_q    (bit_q)
   );

   sar_out_stage #(
      .PARK_LOW (PARK_LOW)
   ) u_out (
      .state       (state),
      .bit_q       (bit_q),
      .sdo         (sdo),
      .sdo_en      (sdo_en),
      .analog_idle (analog_idle),
      .full_pd     (full_pd)
   );

endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
   parameter int RES_BITS = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n,
   input logic                dclk,
   input logic                sdo,
   input logic                sdo_en,
   input logic [RES_BITS-1:0] trial,
   input logic                full_pd
);

   logic seen, spent, en_q, cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen  <= 1'b0;
         spent <= 1'b0;
         en_q  <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         seen <= 1'b1;
         en_q <= sdo_en;
         cs_q <= cs_n;
         if (cs_n)                                    spent <= 1'b0;
         else if (en_q && !sdo_en && !cs_q)           spent <= 1'b1;
      end
   end

   // R8
   cs_high_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $past(cs_n) |-> full_pd && !sdo_en && (trial == '0));

   // R2
   null_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_en) |-> !sdo);

   // R6
   spent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spent && !cs_n |-> !sdo_en);

   // R10
   trial_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !$stable(trial) && !$past(cs_n) |-> !$past(dclk));

endmodule

bind sar_serial_seq sar_serial_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .dclk    (dclk),
   .sdo     (sdo),
   .sdo_en  (sdo_en),
   .trial   (trial),
   .full_pd (full_pd)
);

// File: tb/sim_sar_serial_seq.sv
`timescale 1ns/1ps
module sim_sar_serial_seq;

   localparam int NB = 12;
   localparam int H  = 3;   // clk cycles per data-clock half period
   localparam int NV = 8;
   // Ideal input codes; the expected word equals the code (straight binary)
   localparam logic [NB-1:0] VEC [NV] = '{
      12'h000, 12'hFFF, 12'h800, 12'h7FF,
      12'hA5A, 12'h123, 12'h001, 12'hC3E
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b0;
   logic          dclk = 1'b0;
   logic          cmp_keep;
   logic          sdo, sdo_en, analog_idle, full_pd;
   logic [NB-1:0] trial;
   logic [NB-1:0] ain = '0;
   int            tests = 0;
   int            failed = 0;

   always #2 clk = ~clk;

   // Comparator model: keep the bit while the input is at or above the trial
   assign cmp_keep = (ain >= trial);

   sar_serial_seq u0 (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .dclk (dclk),
      .cmp_keep (cmp_keep), .sdo (sdo), .sdo_en (sdo_en), .trial (trial),
      .analog_idle (analog_idle), .full_pd (full_pd)
   );

   task automatic chk(input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse();
      dclk = 1'b1;
      repeat (H) @(negedge clk);
      dclk = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic open_frame(input logic [NB-1:0] code);
      ain  = code;
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic close_frame();
      cs_n = 1'b1;
      dclk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic full_frame(input logic [NB-1:0] code);
      logic [NB-1:0] hi_mask, exp_t;
      open_frame(code);
      chk("R11 idle low in sampling", analog_idle, 1'b0);
      chk("R11 no powerdown while selected", full_pd, 1'b0);
      pulse();
      chk("R2 first fall keeps output off", sdo_en, 1'b0);
      pulse();
      chk("R2 null bit enable", sdo_en, 1'b1);
      chk("R2 null bit low", sdo, 1'b0);
      chk("R10 first trial word", trial, 12'h800);
      for (int i = 0; i < NB; i++) begin
         pulse();
         chk(i == 0 ? "R4 first decided bit on line" : "R3 msb-first bit",
             {sdo_en, sdo}, {1'b1, code[NB-1-i]});
         hi_mask = ~((12'h001 << (NB - 1 - i)) - 12'h001);
         exp_t   = (code & hi_mask) |
                   ((i < NB - 1) ? (12'h001 << (NB - 2 - i)) : 12'h000);
         chk("R10 trial word progress", trial, exp_t);
         chk("R11 idle after last decision", analog_idle, (i == NB - 1));
      end
      chk("R9 straight binary result", trial, code);
      for (int j = 1; j < NB; j++) begin
         pulse();
         chk("R5 lsb-first replay", {sdo_en, sdo}, {1'b1, code[j]});
      end
      pulse();
      chk("R6 output off after replay", sdo_en, 1'b0);
      repeat (3) pulse();
      chk("R6 further clocks no effect", {sdo_en, sdo}, 2'b00);
      close_frame();
      chk("R8 powerdown on release", {full_pd, sdo_en}, 2'b10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      // R1: reset released while the select line is already low
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 output off after reset", sdo_en, 1'b0);
      chk("R1 trial zero after reset", trial, 12'h000);
      chk("R1 no powerdown with select low", full_pd, 1'b0);
      ain = 12'h555;
      repeat (4) pulse();
      chk("R7 locked until select high", {sdo_en, trial}, 13'h0000);
      close_frame();
      chk("R8 powerdown with select high", full_pd, 1'b1);

      // Table walk: one complete frame per input code
      for (int v = 0; v < NV; v++) full_frame(VEC[v]);

      // R8: short-cycle abort after five result bits
      open_frame(12'hA5A);
      repeat (7) pulse();
      chk("R8 bits flowing before abort", sdo_en, 1'b1);
      cs_n = 1'b1;
      @(negedge clk);
      chk("R8 abort disables output", sdo_en, 1'b0);
      chk("R8 abort powers down", full_pd, 1'b1);
      chk("R8 abort clears trial", trial, 12'h000);
      repeat (2) @(negedge clk);
      full_frame(12'h5A5);

      // R7: held select after a frame never restarts
      open_frame(12'h3C3);
      repeat (27) pulse();
      chk("R6 frame spent", sdo_en, 1'b0);
      repeat (20) pulse();
      chk("R7 no restart without release", sdo_en, 1'b0);
      close_frame();
      full_frame(12'h3C3);

      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

endmodule